// File: doc/BRIEF.md
# Programmable Ring Signal Detector

This block decides whether an incoming telephone line is ringing. It reads a stream of signed receive-path amplitude samples, one per strobe at a fixed sample rate. It can also use a discrete ring-detect input from an opto-isolator instead. A single threshold register picks the source. For the sample path, it also sets the amplitude level and says whether the ring frequency must be checked.

Each ring burst that passes the source test is timed in ticks, and its on and off durations are compared against programmed cadence windows. The block gives a one-clock `ring_pulse` when an on-period qualifies. It holds `ring_valid` high once a complete on/off pattern has matched. Software programs the limits through a plain write port, one 8-bit register per address.

Top module: `ring_detector`

## Requirements
- R1: After reset both outputs are low, every configuration register is zero (so the discrete input is the source), and the cadence logic is idle.
- R2: With the threshold register equal to 0, the discrete ring input alone is the ring source and the amplitude samples have no effect.
- R3: With a threshold value from 1 to 127, ringing is taken from the samples with both the amplitude test and the frequency test applied, and the discrete input has no effect.
- R4: With a threshold value from 129 to 255, ringing is taken from the samples with only the amplitude test, using bits 6:0 as the level.
- R5: A period is the number of samples between two positive-going zero crossings. A crossing is a sample with the sign bit clear whose predecessor had it set. Ringing counts as present only after three consecutive periods fall inside [minimum, maximum] inclusive. Any period outside that range restarts the count.
- R6: The envelope turns on at the first sample with |sample| >= level. It stays on while a sample with |sample| >= level - level/4 occurs within every run of `HOLD_SAMPLES` samples. This gives a release level below the attack level.
- R7: Durations are counted in whole ticks of `TICK_SAMPLES` samples. A measured count m matches a programmed value p when p != 0 and 4p <= 5m <= 6p, which is a window of plus or minus 20 percent.
- R8: In single mode (mode bit 0 = 0), an on-period that matches the on time of pair A or pair B is qualified. The off-period that follows must match the off time of a pair whose on time matched, and when it does `ring_valid` is set.
- R9: In dual mode (mode bit 0 = 1), the pattern on1, off1, on2, off2 must match in that order. Each matched on-period is qualified, and `ring_valid` is set when off2 matches.
- R10: An on-period or off-period that fails its match sends the cadence logic to idle and clears `ring_valid`. No pulse is given for a failed on-period.
- R11: An off-period that reaches 255 ticks sends the cadence logic to idle and clears `ring_valid`.
- R12: `ring_pulse` is high for exactly one clock, in the clock after the sample that ends a qualified on-period.
- R13: The register map is: address 0 threshold, 1 minimum period, 2 maximum period, 3 mode (bit 0), and 4 to 11 the cadence times in the order on A, off A, on B, off B, on1, off1, on2, off2.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sample_vld | input | 1 | Strobe for one amplitude sample |
| sample_in | input | SAMPLE_W | Signed receive-path amplitude sample |
| opto_ring_in | input | 1 | Discrete ring-detect input, high while ringing |
| cfg_we | input | 1 | Configuration write enable |
| cfg_addr | input | 4 | Configuration register address |
| cfg_wdata | input | 8 | Configuration write data |
| ring_pulse | output | 1 | One-clock pulse per qualified on-period |
| ring_valid | output | 1 | Cadence pattern matched |

## Verification
`ring_pulse` is due one clock after the sample that ends an on-period. A rise of `ring_valid` is due one clock after the sample that ends the matching off-period. A fall of `ring_valid` is due one clock after a failed match or the 255th off tick. When the source is the sample stream, the envelope hold and the three-period tone test move both edges by up to a tick. For that reason the bench sets each burst length to the middle of a tick and leaves room inside the 20 percent window. The bench queues the events each stimulus must produce and checks them in order of arrival, not at fixed cycles. After each stimulus it waits for the gap to settle and then checks that the queue is empty and that no other event appeared.

// File: rtl/ring_det_pkg.sv
package ring_det_pkg;
    parameter int REG_W  = 8;
    parameter int ADDR_W = 4;
    localparam int NUM_CAD = 8;

    typedef logic [REG_W-1:0] reg_t;

    typedef struct packed {
        reg_t                thr;
        reg_t                per_min;
        reg_t                per_max;
        logic                dual;
        reg_t [NUM_CAD-1:0]  cad;
    } cfg_t;

    // address map
    localparam int ADR_THR  = 0;
    localparam int ADR_PMIN = 1;
    localparam int ADR_PMAX = 2;
    localparam int ADR_MODE = 3;
    localparam int ADR_CAD0 = 4;

    // cadence slot order
    localparam int CAD_ON_A  = 0;
    localparam int CAD_OFF_A = 1;
    localparam int CAD_ON_B  = 2;
    localparam int CAD_OFF_B = 3;
    localparam int CAD_ON_1  = 4;
    localparam int CAD_OFF_1 = 5;
    localparam int CAD_ON_2  = 6;
    localparam int CAD_OFF_2 = 7;

    typedef enum logic [1:0] {CS_IDLE, CS_ON, CS_OFF} cad_st_e;
endpackage

// File: rtl/ring_cfg_regs.sv
module ring_cfg_regs
    import ring_det_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [ADDR_W-1:0] addr,
    input  reg_t              wdata,
    output cfg_t              cfg
);
    cfg_t cfg_d, cfg_q;

    always_comb begin
        cfg_d = cfg_q;
        if (we) begin
            if (addr == ADDR_W'(ADR_THR))  cfg_d.thr     = wdata;
            if (addr == ADDR_W'(ADR_PMIN)) cfg_d.per_min = wdata;
            if (addr == ADDR_W'(ADR_PMAX)) cfg_d.per_max = wdata;
            if (addr == ADDR_W'(ADR_MODE)) cfg_d.dual    = wdata[0];
            for (int i = 0; i < NUM_CAD; i++) begin
                if (addr == ADDR_W'(ADR_CAD0 + i)) cfg_d.cad[i] = wdata;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) cfg_q <= '0;
        else        cfg_q <= cfg_d;
    end

    assign cfg = cfg_q;

    AST_CFG_THR_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        (we && addr == ADDR_W'(ADR_THR)) |=> (cfg_q.thr == $past(wdata))); // R13
endmodule

// File: rtl/ring_energy_det.sv
module ring_energy_det
    import ring_det_pkg::*;
#(
    parameter int SAMPLE_W     = 8,
    parameter int HOLD_SAMPLES = 32
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                sample_vld,
    input  logic [SAMPLE_W-1:0] sample,
    input  logic [REG_W-2:0]    level,
    input  logic                chk_freq,
    input  reg_t                per_min,
    input  reg_t                per_max,
    output logic                raw_o
);
    localparam int HOLD_W = $clog2(HOLD_SAMPLES + 1);
    localparam int CMP_W  = (SAMPLE_W > REG_W) ? SAMPLE_W : REG_W;
    localparam int GOOD_N = 3;

    typedef struct packed {
        logic              prev_neg;
        reg_t              per;
        logic [1:0]        good;
        logic [HOLD_W-1:0] hold;
        logic              env;
    } en_st_t;

    en_st_t st_d, st_q;
    logic [SAMPLE_W-1:0] mag;
    logic [CMP_W-1:0]    mag_x, att_x, rel_x;
    logic                attack, keep, crossing;

    always_comb begin
        mag   = sample[SAMPLE_W-1] ? (~sample + 1'b1) : sample;
        mag_x = CMP_W'(mag);
        att_x = CMP_W'(level);
        rel_x = att_x - (att_x >> 2);
        attack   = (att_x != '0) && (mag_x >= att_x);
        keep     = (att_x != '0) && (mag_x >= rel_x);
        crossing = st_q.prev_neg && !sample[SAMPLE_W-1];
    end

    always_comb begin
        st_d = st_q;
        if (sample_vld) begin
            st_d.prev_neg = sample[SAMPLE_W-1];
            if (crossing) begin
                st_d.per = reg_t'(1);
                if (st_q.per >= per_min && st_q.per <= per_max)
                    st_d.good = (st_q.good == 2'(GOOD_N)) ? st_q.good : st_q.good + 2'd1;
                else
                    st_d.good = '0;
            end else if (st_q.per != '1) begin
                st_d.per = st_q.per + 1'b1;
            end
            if (!st_q.env) begin
                if (attack) begin
                    st_d.env  = 1'b1;
                    st_d.hold = HOLD_W'(HOLD_SAMPLES);
                end
            end else if (keep) begin
                st_d.hold = HOLD_W'(HOLD_SAMPLES);
            end else if (st_q.hold == '0) begin
                st_d.env = 1'b0;
            end else begin
                st_d.hold = st_q.hold - 1'b1;
            end
            if (!st_d.env) st_d.good = '0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign raw_o = st_q.env && (!chk_freq || st_q.good == 2'(GOOD_N));

    AST_ENV_ATTACK: assert property (@(posedge clk) disable iff (!rst_n)
        (sample_vld && !st_q.env && attack) |=> st_q.env); // R6
    AST_ENV_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(st_q.env) |-> $past(sample_vld && !keep && st_q.hold == '0)); // R6
endmodule

// File: rtl/ring_cadence.sv
module ring_cadence
    import ring_det_pkg::*;
#(
    parameter int TICK_SAMPLES = 80
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               sample_vld,
    input  logic               raw_i,
    input  logic               dual,
    input  reg_t [NUM_CAD-1:0] cad,
    output logic               ring_pulse_o,
    output logic               ring_valid_o
);
    localparam int SUB_W = $clog2(TICK_SAMPLES + 1);
    localparam int WIDE  = REG_W + 3;

    typedef struct packed {
        cad_st_e          st;
        logic [SUB_W-1:0] sub;
        reg_t             cnt;
        logic             cand_a;
        logic             cand_b;
        logic             phase;
        logic             valid;
        logic             pulse;
    } cd_st_t;

    cd_st_t st_d, st_q;

    function automatic logic near(input reg_t m, input reg_t p);
        logic [WIDE-1:0] m5, p4, p6;
        m5 = (WIDE'(m) << 2) + WIDE'(m);
        p4 = WIDE'(p) << 2;
        p6 = (WIDE'(p) << 2) + (WIDE'(p) << 1);
        return (p != '0) && (m5 >= p4) && (m5 <= p6);
    endfunction

    logic on_a, on_b, on_ph, off_ok;

    always_comb begin
        on_a  = near(st_q.cnt, cad[CAD_ON_A]);
        on_b  = near(st_q.cnt, cad[CAD_ON_B]);
        on_ph = near(st_q.cnt, st_q.phase ? cad[CAD_ON_2] : cad[CAD_ON_1]);
        if (!dual)
            off_ok = (st_q.cand_a && near(st_q.cnt, cad[CAD_OFF_A])) ||
                     (st_q.cand_b && near(st_q.cnt, cad[CAD_OFF_B]));
        else
            off_ok = near(st_q.cnt, st_q.phase ? cad[CAD_OFF_2] : cad[CAD_OFF_1]);
    end

    always_comb begin
        st_d       = st_q;
        st_d.pulse = 1'b0;
        if (sample_vld) begin
            unique case (st_q.st)
                CS_IDLE: begin
                    st_d.phase = 1'b0;
                    if (raw_i) begin
                        st_d.st  = CS_ON;
                        st_d.sub = SUB_W'(1);
                        st_d.cnt = '0;
                    end
                end
                CS_ON: begin
                    if (raw_i) begin
                        if (st_q.sub == SUB_W'(TICK_SAMPLES - 1)) begin
                            st_d.sub = '0;
                            if (st_q.cnt != '1) st_d.cnt = st_q.cnt + 1'b1;
                        end else begin
                            st_d.sub = st_q.sub + 1'b1;
                        end
                    end else if (dual ? on_ph : (on_a || on_b)) begin
                        st_d.cand_a = on_a;
                        st_d.cand_b = on_b;
                        st_d.pulse  = 1'b1;
                        st_d.st     = CS_OFF;
                        st_d.sub    = SUB_W'(1);
                        st_d.cnt    = '0;
                    end else begin
                        st_d.st    = CS_IDLE;
                        st_d.valid = 1'b0;
                        st_d.phase = 1'b0;
                    end
                end
                CS_OFF: begin
                    if (!raw_i) begin
                        if (st_q.cnt == '1) begin
                            st_d.st    = CS_IDLE;
                            st_d.valid = 1'b0;
                            st_d.phase = 1'b0;
                        end else if (st_q.sub == SUB_W'(TICK_SAMPLES - 1)) begin
                            st_d.sub = '0;
                            st_d.cnt = st_q.cnt + 1'b1;
                        end else begin
                            st_d.sub = st_q.sub + 1'b1;
                        end
                    end else if (off_ok) begin
                        st_d.st  = CS_ON;
                        st_d.sub = SUB_W'(1);
                        st_d.cnt = '0;
                        if (!dual || st_q.phase) st_d.valid = 1'b1;
                        st_d.phase = dual && !st_q.phase;
                    end else begin
                        st_d.st    = CS_IDLE;
                        st_d.valid = 1'b0;
                        st_d.phase = 1'b0;
                    end
                end
                default: st_d.st = CS_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '{st: CS_IDLE, default: '0};
        else        st_q <= st_d;
    end

    assign ring_pulse_o = st_q.pulse;
    assign ring_valid_o = st_q.valid;

    AST_PULSE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.pulse |=> !st_q.pulse); // R12
    AST_PULSE_AT_FALL: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.pulse |-> $past(sample_vld && !raw_i)); // R12
    AST_VALID_ON_RISE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(st_q.valid) |-> $past(sample_vld && raw_i)); // R8
    AST_IDLE_NOT_VALID: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.st == CS_IDLE) |-> !st_q.valid); // R10
endmodule

// File: rtl/ring_detector.sv
module ring_detector
    import ring_det_pkg::*;
#(
    parameter int SAMPLE_W     = 8,
    parameter int TICK_SAMPLES = 80,
    parameter int HOLD_SAMPLES = 32
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                sample_vld,
    input  logic [SAMPLE_W-1:0] sample_in,
    input  logic                opto_ring_in,
    input  logic                cfg_we,
    input  logic [ADDR_W-1:0]   cfg_addr,
    input  logic [REG_W-1:0]    cfg_wdata,
    output logic                ring_pulse,
    output logic                ring_valid
);
    cfg_t cfg;
    logic energy_raw, use_opto, chk_freq, src_raw;

    ring_cfg_regs u_cfg (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (cfg_we),
        .addr  (cfg_addr),
        .wdata (cfg_wdata),
        .cfg   (cfg)
    );

    assign use_opto = (cfg.thr == '0);
    assign chk_freq = !cfg.thr[REG_W-1];

    ring_energy_det #(
        .SAMPLE_W     (SAMPLE_W),
        .HOLD_SAMPLES (HOLD_SAMPLES)
    ) u_energy (
        .clk        (clk),
        .rst_n      (rst_n),
        .sample_vld (sample_vld),
        .sample     (sample_in),
        .level      (cfg.thr[REG_W-2:0]),
        .chk_freq   (chk_freq),
        .per_min    (cfg.per_min),
        .per_max    (cfg.per_max),
        .raw_o      (energy_raw)
    );

    assign src_raw = use_opto ? opto_ring_in : energy_raw;

    ring_cadence #(
        .TICK_SAMPLES (TICK_SAMPLES)
    ) u_cadence (
        .clk          (clk),
        .rst_n        (rst_n),
        .sample_vld   (sample_vld),
        .raw_i        (src_raw),
        .dual         (cfg.dual),
        .cad          (cfg.cad),
        .ring_pulse_o (ring_pulse),
        .ring_valid_o (ring_valid)
    );
endmodule

// File: tb/ring_detector_test.sv
module ring_detector_test;
    localparam int TICK = 80;
    localparam real PI = 3.14159265358979;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       sample_vld = 1'b0;
    logic [7:0] sample_in = '0;
    logic       opto_ring_in = 1'b0;
    logic       cfg_we = 1'b0;
    logic [3:0] cfg_addr = '0;
    logic [7:0] cfg_wdata = '0;
    logic       ring_pulse, ring_valid;

    int checks = 0;
    int errors = 0;

    typedef enum int {EV_PULSE, EV_VRISE, EV_VFALL} ev_e;
    typedef struct {
        ev_e   ev;
        string req;
    } exp_t;
    exp_t exp_q[$];

    always #5 clk = ~clk;

    ring_detector uut (
        .clk          (clk),
        .rst_n        (rst_n),
        .sample_vld   (sample_vld),
        .sample_in    (sample_in),
        .opto_ring_in (opto_ring_in),
        .cfg_we       (cfg_we),
        .cfg_addr     (cfg_addr),
        .cfg_wdata    (cfg_wdata),
        .ring_pulse   (ring_pulse),
        .ring_valid   (ring_valid)
    );

    task automatic check(input bit ok, input string req, input int act, input int expv);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
        end
    endtask

    task automatic expect_ev(input ev_e ev, input string req);
        exp_t e;
        e.ev  = ev;
        e.req = req;
        exp_q.push_back(e);
    endtask

    // monitor: pops the scoreboard as events appear
    logic prev_pulse = 1'b0;
    logic prev_valid = 1'b0;

    task automatic got(input ev_e ev);
        exp_t e;
        if (exp_q.size() == 0) begin
            check(1'b0, "unexpected event R10", int'(ev), -1);
        end else begin
            e = exp_q.pop_front();
            check(e.ev == ev, e.req, int'(ev), int'(e.ev));
        end
    endtask

    always @(negedge clk) begin
        if (rst_n) begin
            if (ring_pulse) begin
                got(EV_PULSE);
                if (prev_pulse) check(1'b0, "R12 pulse width", 2, 1);
            end
            if (ring_valid && !prev_valid) got(EV_VRISE);
            if (!ring_valid && prev_valid) got(EV_VFALL);
            prev_pulse = ring_pulse;
            prev_valid = ring_valid;
        end
    end

    task automatic wr(input int a, input int d);
        @(posedge clk); #1;
        cfg_we = 1'b1; cfg_addr = 4'(a); cfg_wdata = 8'(d);
        @(posedge clk); #1;
        cfg_we = 1'b0;
    endtask

    task automatic opto(input logic lvl, input int n);
        for (int i = 0; i < n; i++) begin
            @(posedge clk); #1;
            opto_ring_in = lvl;
        end
    endtask

    task automatic tone(input real amp, input int per, input int n);
        for (int i = 0; i < n; i++) begin
            real r;
            int  v;
            r = amp * $sin(2.0 * PI * (real'(i) + 0.5) / real'(per));
            v = (r >= 0.0) ? $rtoi(r + 0.5) : -$rtoi(-r + 0.5);
            @(posedge clk); #1;
            sample_in = 8'(v);
        end
    endtask

    task automatic quiet(input int n);
        for (int i = 0; i < n; i++) begin
            @(posedge clk); #1;
            sample_in = '0;
        end
    endtask

    task automatic drained(input string req);
        repeat (4) @(negedge clk);
        check(exp_q.size() == 0, req, exp_q.size(), 0);
    endtask

    function automatic int tk(input real t);
        return $rtoi(t * real'(TICK));
    endfunction

    initial begin
        repeat (1500) begin
            @(posedge clk);
        end
        repeat (148500) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog expired");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        @(negedge clk);
        check(ring_pulse == 1'b0, "R1 pulse after reset", int'(ring_pulse), 0);
        check(ring_valid == 1'b0, "R1 valid after reset", int'(ring_valid), 0);

        // R13 register map
        wr(1, 16); wr(2, 24); wr(3, 0);
        wr(4, 10); wr(5, 20); wr(6, 5); wr(7, 5);
        wr(8, 4);  wr(9, 3);  wr(10, 8); wr(11, 20);
        sample_vld = 1'b1;

        // single mode, discrete source (threshold 0 after reset, R1 R2)
        opto(0, 100);
        expect_ev(EV_PULSE, "R8 on A qualified (R2 discrete source)");
        opto(1, tk(10.5)); opto(0, tk(20.5));
        expect_ev(EV_VRISE, "R8 A pattern matched");
        expect_ev(EV_PULSE, "R12 pulse at end of on");
        opto(1, tk(10.5)); opto(0, tk(20.5));
        expect_ev(EV_PULSE, "R8 on B qualified");
        opto(1, tk(5.5)); opto(0, tk(5.5));
        opto(1, 2);
        @(negedge clk);
        check(ring_valid == 1'b1, "R8 B off kept valid", int'(ring_valid), 1);
        expect_ev(EV_VFALL, "R10 on mismatch clears valid");
        opto(1, tk(7.5) - 2); opto(0, 200);
        drained("R7 window rejects 7 ticks");

        expect_ev(EV_PULSE, "R10 recovery from idle");
        opto(1, tk(10.5)); opto(0, tk(12.5));
        opto(1, 3);
        @(negedge clk);
        check(ring_valid == 1'b0, "R10 off mismatch", int'(ring_valid), 0);
        expect_ev(EV_PULSE, "R10 counted from idle");
        opto(1, tk(10.5) - 3); opto(0, tk(20.5));
        expect_ev(EV_VRISE, "R8 valid again");
        expect_ev(EV_PULSE, "R8 on again");
        opto(1, tk(10.5));
        expect_ev(EV_VFALL, "R11 off timeout");
        opto(0, 21000);
        drained("R11 timeout drained");

        // dual mode
        wr(3, 1);
        expect_ev(EV_PULSE, "R9 on1");
        opto(1, tk(4.5)); opto(0, tk(3.5));
        expect_ev(EV_PULSE, "R9 on2");
        opto(1, tk(8.5)); opto(0, tk(20.5));
        expect_ev(EV_VRISE, "R9 pattern matched");
        expect_ev(EV_PULSE, "R9 on1 again");
        opto(1, tk(4.5)); opto(0, tk(3.5));
        expect_ev(EV_PULSE, "R9 on2 again");
        opto(1, tk(8.5)); opto(0, tk(20.5));
        expect_ev(EV_VFALL, "R9 order enforced (R10)");
        opto(1, tk(8.5)); opto(0, 200);
        drained("R9 dual drained");
        check(ring_valid == 1'b0, "R10 valid low after fail", int'(ring_valid), 0);

        // sample source
        wr(3, 0);
        wr(0, 60);
        expect_ev(EV_PULSE, "R3 in-band tone detected");
        tone(100.0, 20, tk(10.5)); quiet(3000);
        drained("R3 in-band drained");
        tone(100.0, 40, tk(10.5)); quiet(3000);
        drained("R5 out-of-band period rejected");
        wr(0, 128 + 60);
        expect_ev(EV_PULSE, "R4 no frequency check");
        tone(100.0, 40, tk(10.5)); quiet(3000);
        drained("R4 drained");
        wr(0, 60);
        tone(50.0, 20, tk(10.5)); quiet(3000);
        drained("R6 below attack ignored");
        expect_ev(EV_PULSE, "R6 release hysteresis holds burst");
        tone(100.0, 20, 200); tone(50.0, 20, tk(10.5) - 200); quiet(3000);
        drained("R6 drained");
        opto(1, tk(10.5)); opto(0, 3000);
        drained("R3 discrete input ignored");
        wr(0, 0);
        tone(100.0, 20, tk(10.5)); quiet(3000);
        drained("R2 samples ignored");
        check(ring_valid == 1'b0, "R2 valid low", int'(ring_valid), 0);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule